// File: doc/BRIEF.md
# Integer Execute Stage with Compare Flags

This block is the execute stage of a small 32-bit RISC core. Each clock it accepts one decoded operation: a 5-bit opcode, a flag choosing between a register and an immediate second operand, the two register values and an 18-bit immediate field. The upper two bits of that field select how the 16-bit immediate grows to 32 bits. The lower sixteen bits hold the immediate value.

The block produces a combinational 32-bit result and a write-enable for the register file. It also holds a registered pair of condition flags, "equal" and "greater-than". Only the compare operation writes these flags, and branch logic elsewhere in the core reads them. Fetch, the register file, memory access and branching sit outside this block.

Top module: `int_exec_stage`

## Requirements
- R1: Opcode 00000 gives rs1 plus operand B and opcode 00001 gives rs1 minus operand B, both modulo 2^32, with `result_we` high.
- R2: Opcode 00010 gives the low 32 bits of the product of rs1 and operand B, with `result_we` high.
- R3: Opcode 00011 gives the signed quotient and opcode 00100 the signed remainder of rs1 by operand B, with the quotient truncated toward zero. Division by zero gives a quotient of all ones and a remainder equal to rs1. The case 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R4: Opcode 00110 is bitwise AND and opcode 00111 is bitwise OR of rs1 and operand B. Opcode 01000 gives the complement of operand B and opcode 01001 passes operand B through. Both of the last two ignore rs1.
- R5: Opcode 01010 shifts rs1 left and opcode 01011 shifts it right, both filling with zeros. Opcode 01100 shifts right while copying the sign bit. All three take the shift amount from bits 4:0 of operand B.
- R6: When `imm_sel` is 0, operand B is `src_b`. When it is 1, operand B is the extended immediate.
- R7: The immediate is `imm_field[15:0]`, and the mode is `imm_field[17:16]`. Mode 00 sign-extends it, 01 zero-extends it and 10 places it in bits 31:16 with zeros below. Mode 11 behaves like 00.
- R8: Opcode 00101 (compare) loads the flags at the next rising edge. The equal flag is set when rs1 equals operand B. The greater-than flag is set when rs1 is greater than operand B in signed order.
- R9: Every opcode other than compare leaves both flags unchanged.
- R10: For compare and for the unused opcodes 01101 to 11111, `result_we` is 0 and `result` is 0.
- R11: A clock edge with `rst_n` low clears both flags to 0, even when a compare is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 5 | Operation code |
| imm_sel | input | 1 | 1 selects the extended immediate as operand B |
| src_a | input | 32 | First register operand (rs1) |
| src_b | input | 32 | Second register operand (rs2) |
| imm_field | input | 18 | Bits 17:16 extension mode, bits 15:0 immediate |
| result | output | 32 | Operation result, combinational |
| result_we | output | 1 | High when `result` should be written back |
| flag_eq | output | 1 | Registered equal flag |
| flag_gt | output | 1 | Registered signed greater-than flag |

## Verification
The assertions assume that every input carries a known, non-X value at each rising edge once reset is released. They also assume that an operation is present on every clock, because the block has no valid qualifier and treats each cycle's opcode as an issued instruction. The compare-result property only covers the register form, so it relies on `src_b` being the real operand whenever `imm_sel` is low. The bench drives every input at the falling edge from fully defined values, including the reserved opcodes and the reserved extension mode on purpose. It never leaves a bit undriven.

// File: rtl/exu_pkg.sv
// Package: exu_pkg
// Shared operation codes and immediate-extension modes for the execute stage.
// Assumes a 5-bit opcode space. Only the first thirteen codes are executed here.
package exu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'b00000,
        OP_SUB = 5'b00001,
        OP_MUL = 5'b00010,
        OP_DIV = 5'b00011,
        OP_MOD = 5'b00100,
        OP_CMP = 5'b00101,
        OP_AND = 5'b00110,
        OP_OR  = 5'b00111,
        OP_NOT = 5'b01000,
        OP_MOV = 5'b01001,
        OP_LSL = 5'b01010,
        OP_LSR = 5'b01011,
        OP_ASR = 5'b01100
    } exu_op_e;

    typedef enum logic [1:0] {
        MOD_SEXT = 2'b00,
        MOD_ZEXT = 2'b01,
        MOD_HIGH = 2'b10,
        MOD_RSVD = 2'b11
    } imm_mod_e;

endpackage

// File: rtl/exu_operand.sv
// Module: exu_operand
// Forms operand B. It widens the immediate according to the two mode bits at the
// top of the immediate field, then picks the immediate or the register value.
// Assumes DATA_W > IMM_W. The reserved mode falls back to sign extension.
module exu_operand
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              imm_sel,
    input  logic [IMM_W+1:0]  imm_field,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int FIELD_W = IMM_W + 2;
    localparam int PAD_W   = DATA_W - IMM_W;

    logic [IMM_W-1:0]  imm_raw;
    imm_mod_e          imm_mode;
    logic [DATA_W-1:0] imm_ext;

    assign imm_raw  = imm_field[IMM_W-1:0];
    assign imm_mode = imm_mod_e'(imm_field[FIELD_W-1 -: 2]);

    // Widen the immediate according to its mode.
    always_comb begin
        case (imm_mode)
            MOD_ZEXT: imm_ext = {{PAD_W{1'b0}}, imm_raw};
            MOD_HIGH: imm_ext = {imm_raw, {PAD_W{1'b0}}};
            default:  imm_ext = {{PAD_W{imm_raw[IMM_W-1]}}, imm_raw};
        endcase
    end

    // Choose between the register operand and the widened immediate.
    assign opnd_b = imm_sel ? imm_ext : src_b;

endmodule

// File: rtl/exu_arith.sv
// Module: exu_arith
// Add, subtract, multiply, signed divide and signed remainder.
// A zero divisor gives all ones and the dividend. The overflow case of the most
// negative value divided by -1 gives that value and a zero remainder.
// Opcodes it does not own produce zero.
module exu_arith
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [4:0]        opcode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] arith_res
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0]        sum, diff, prod, quot, rem;
    logic signed [DATA_W-1:0] quot_raw, rem_raw;
    logic                     div_zero, div_ovf;

    assign sum  = opnd_a + opnd_b;
    assign diff = opnd_a - opnd_b;
    assign prod = opnd_a * opnd_b;

    assign div_zero = (opnd_b == '0);
    assign div_ovf  = (opnd_a == MOST_NEG) && (&opnd_b);

    // The raw signed divider. Its output is discarded in the special cases.
    assign quot_raw = $signed(opnd_a) / $signed(opnd_b);
    assign rem_raw  = $signed(opnd_a) % $signed(opnd_b);

    // Replace the raw divider output for a zero divisor and for overflow.
    always_comb begin
        if (div_zero) begin
            quot = '1;
            rem  = opnd_a;
        end else if (div_ovf) begin
            quot = MOST_NEG;
            rem  = '0;
        end else begin
            quot = quot_raw;
            rem  = rem_raw;
        end
    end

    // Select the arithmetic result for this opcode.
    always_comb begin
        case (opcode)
            OP_ADD:  arith_res = sum;
            OP_SUB:  arith_res = diff;
            OP_MUL:  arith_res = prod;
            OP_DIV:  arith_res = quot;
            OP_MOD:  arith_res = rem;
            default: arith_res = '0;
        endcase
    end

endmodule

// File: rtl/exu_bitops.sv
// Module: exu_bitops
// Bitwise operations, pass-through and the three shifts.
// The shift amount is the low log2(DATA_W) bits of operand B.
// Opcodes it does not own produce zero.
module exu_bitops
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [4:0]        opcode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] bit_res
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    assign shamt = opnd_b[SH_W-1:0];

    // Select the logic or shift result for this opcode.
    always_comb begin
        case (opcode)
            OP_AND:  bit_res = opnd_a & opnd_b;
            OP_OR:   bit_res = opnd_a | opnd_b;
            OP_NOT:  bit_res = ~opnd_b;
            OP_MOV:  bit_res = opnd_b;
            OP_LSL:  bit_res = opnd_a << shamt;
            OP_LSR:  bit_res = opnd_a >> shamt;
            OP_ASR:  bit_res = $unsigned($signed(opnd_a) >>> shamt);
            default: bit_res = '0;
        endcase
    end

endmodule

// File: rtl/exu_flags.sv
// Module: exu_flags
// Holds the equal and signed greater-than flags. They load only when cmp_en is
// high, and a synchronous active-low reset clears them.
module exu_flags #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              eq_q,
    output logic              gt_q
);
    // Clear on reset, load on compare, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
            gt_q <= 1'b0;
        end else if (cmp_en) begin
            eq_q <= (opnd_a == opnd_b);
            gt_q <= ($signed(opnd_a) > $signed(opnd_b));
        end
    end

endmodule

// File: rtl/int_exec_stage.sv
// Module: int_exec_stage
// The execute stage. It forms operand B, runs the arithmetic and bit units in
// parallel, picks the result by opcode class and raises the write-enable for the
// opcodes that produce a result. The flags are updated only on compare.
// Assumes one operation is presented on every clock.
module int_exec_stage
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        opcode,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W+1:0]  imm_field,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_eq,
    output logic              flag_gt
);
    logic [DATA_W-1:0] opnd_b, arith_res, bit_res;
    logic              is_arith, is_bit, is_cmp;

    exu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_operand (
        .imm_sel   (imm_sel),
        .imm_field (imm_field),
        .src_b     (src_b),
        .opnd_b    (opnd_b)
    );

    exu_arith #(.DATA_W(DATA_W)) i_arith (
        .opcode    (opcode),
        .opnd_a    (src_a),
        .opnd_b    (opnd_b),
        .arith_res (arith_res)
    );

    exu_bitops #(.DATA_W(DATA_W)) i_bitops (
        .opcode  (opcode),
        .opnd_a  (src_a),
        .opnd_b  (opnd_b),
        .bit_res (bit_res)
    );

    exu_flags #(.DATA_W(DATA_W)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (is_cmp),
        .opnd_a (src_a),
        .opnd_b (opnd_b),
        .eq_q   (flag_eq),
        .gt_q   (flag_gt)
    );

    // Sort the opcode into its execution class.
    always_comb begin
        is_arith = opcode inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD};
        is_bit   = opcode inside {OP_AND, OP_OR, OP_NOT, OP_MOV,
                                  OP_LSL, OP_LSR, OP_ASR};
        is_cmp   = (opcode == OP_CMP);
    end

    // Drive the result and write-enable from the active class.
    always_comb begin
        result_we = is_arith | is_bit;
        if (is_arith)    result = arith_res;
        else if (is_bit) result = bit_res;
        else             result = '0;
    end

endmodule

// File: rtl/exu_checker.sv
// Module: exu_checker
// Properties for int_exec_stage, attached with bind. It only observes ports.
// Assumes the inputs are never X at a rising edge after reset.
module exu_checker
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        opcode,
    input logic              imm_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W+1:0]  imm_field,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic              flag_eq,
    input logic              flag_gt
);
    logic armed   = 1'b0;
    logic running = 1'b0;

    // armed: at least one edge has passed, so $past is defined.
    always_ff @(posedge clk) armed <= 1'b1;

    // running: the previous edge was outside reset.
    always_ff @(posedge clk) running <= rst_n;

    p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(rst_n) |-> !flag_eq && !flag_gt);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !(flag_eq && flag_gt));

    p_cmp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running && $past(opcode) == OP_CMP && !$past(imm_sel) |->
            flag_eq == ($past(src_a) == $past(src_b)) &&
            flag_gt == ($signed($past(src_a)) > $signed($past(src_b))));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running && $past(opcode) != OP_CMP |-> $stable(flag_eq) && $stable(flag_gt));

    p_cmp_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_CMP |-> !result_we && result == '0);

    p_reserved_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opcode > OP_ASR |-> !result_we && result == '0);

    p_mov_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_MOV && !imm_sel |-> result_we && result == src_b);

    p_imm_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_MOV && imm_sel && imm_field[IMM_W+1:IMM_W] == 2'b10 |->
            result == {imm_field[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}});

endmodule

bind int_exec_stage exu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_exu_checker (.*);

// File: tb/test_int_exec_stage.sv
// Bench for int_exec_stage. A behavioural model predicts the result, the
// write-enable and the flags, and every clock is compared against it.
module test_int_exec_stage;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] C_ADD = 5'd0,  C_SUB = 5'd1,  C_MUL = 5'd2,
                           C_DIV = 5'd3,  C_MOD = 5'd4,  C_CMP = 5'd5,
                           C_AND = 5'd6,  C_OR  = 5'd7,  C_NOT = 5'd8,
                           C_MOV = 5'd9,  C_LSL = 5'd10, C_LSR = 5'd11,
                           C_ASR = 5'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  opcode = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [17:0] imm_field = '0;
    logic [31:0] result;
    logic        result_we, flag_eq, flag_gt;

    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;
    logic m_eq = 1'b0, m_gt = 1'b0, prev_cmp = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    int_exec_stage i_int_exec_stage (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .imm_sel(imm_sel),
        .src_a(src_a), .src_b(src_b), .imm_field(imm_field),
        .result(result), .result_we(result_we),
        .flag_eq(flag_eq), .flag_gt(flag_gt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_op2(logic isel, logic [31:0] b, logic [17:0] f);
        if (!isel) return b;
        case (f[17:16])
            2'b01:   return {16'h0, f[15:0]};
            2'b10:   return {f[15:0], 16'h0};
            default: return {{16{f[15]}}, f[15:0]};
        endcase
    endfunction

    function automatic logic [31:0] m_res(logic [4:0] op, logic [31:0] a, logic [31:0] b2);
        longint sa, sb, q;
        sa = longint'($signed(a));
        sb = longint'($signed(b2));
        case (op)
            C_ADD: return a + b2;
            C_SUB: return a - b2;
            C_MUL: return a * b2;
            C_DIV: begin
                if (b2 == 0) return 32'hFFFF_FFFF;
                q = sa / sb;
                return q[31:0];
            end
            C_MOD: begin
                if (b2 == 0) return a;
                q = sa % sb;
                return q[31:0];
            end
            C_AND: return a & b2;
            C_OR:  return a | b2;
            C_NOT: return ~b2;
            C_MOV: return b2;
            C_LSL: return a << b2[4:0];
            C_LSR: return a >> b2[4:0];
            C_ASR: begin
                q = sa >>> b2[4:0];
                return q[31:0];
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_we(logic [4:0] op);
        return (op <= C_ASR) && (op != C_CMP);
    endfunction

    function automatic string req_of(logic [4:0] op);
        case (op)
            C_ADD, C_SUB:               return "R1";
            C_MUL:                      return "R2";
            C_DIV, C_MOD:               return "R3";
            C_AND, C_OR, C_NOT, C_MOV:  return "R4";
            C_LSL, C_LSR, C_ASR:        return "R5";
            default:                    return "R10";
        endcase
    endfunction

    function automatic logic [31:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] op, input logic isel, input logic [31:0] a,
                        input logic [31:0] b, input logic [17:0] f, input string req);
        logic [31:0] b2, er;
        logic        ew;
        @(negedge clk);
        rst_n = 1'b1; opcode = op; imm_sel = isel; src_a = a; src_b = b; imm_field = f;
        b2 = m_op2(isel, b, f);
        er = m_res(op, a, b2);
        ew = m_we(op);
        #(CLK_PERIOD/4);
        chk(req, "result", result, er);
        chk(req, "write enable", {31'b0, result_we}, {31'b0, ew});
        chk(prev_cmp ? "R8" : "R9", "flags {eq,gt}",
            {30'b0, flag_eq, flag_gt}, {30'b0, m_eq, m_gt});
        @(posedge clk);
        if (op == C_CMP) begin
            m_eq = (a == b2);
            m_gt = ($signed(a) > $signed(b2));
        end
        prev_cmp = (op == C_CMP);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (cycles) @(posedge clk);
        m_eq = 1'b0; m_gt = 1'b0; prev_cmp = 1'b0;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk("R11", "flags in reset", {30'b0, flag_eq, flag_gt}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r, a, b;
        logic [4:0]  op;
        do_reset(3);

        // R1 add and subtract with wrap
        step(C_ADD, 0, 32'd5, 32'd7, 18'h0, "R1");
        step(C_ADD, 0, 32'hFFFF_FFFF, 32'd1, 18'h0, "R1");
        step(C_SUB, 0, 32'd3, 32'd5, 18'h0, "R1");
        // R2 multiply low half
        step(C_MUL, 0, 32'h0001_0000, 32'h0001_0000, 18'h0, "R2");
        step(C_MUL, 0, 32'd7, 32'hFFFF_FFFD, 18'h0, "R2");
        // R3 signed division and its corner cases
        step(C_DIV, 0, 32'hFFFF_FFF9, 32'd2, 18'h0, "R3");
        step(C_MOD, 0, 32'hFFFF_FFF9, 32'd2, 18'h0, "R3");
        step(C_DIV, 0, 32'd31, 32'd0, 18'h0, "R3");
        step(C_MOD, 0, 32'd31, 32'd0, 18'h0, "R3");
        step(C_DIV, 0, 32'h8000_0000, 32'hFFFF_FFFF, 18'h0, "R3");
        step(C_MOD, 0, 32'h8000_0000, 32'hFFFF_FFFF, 18'h0, "R3");
        // R4 bitwise ops, rs1 ignored by complement and pass-through
        step(C_AND, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 18'h0, "R4");
        step(C_OR,  0, 32'hF000_0001, 32'h000F_0010, 18'h0, "R4");
        step(C_NOT, 0, 32'hDEAD_BEEF, 32'h0000_FFFF, 18'h0, "R4");
        step(C_MOV, 0, 32'hDEAD_BEEF, 32'h1357_9BDF, 18'h0, "R4");
        // R5 shifts, amount from bits 4:0 only
        step(C_LSL, 0, 32'h0000_0002, 32'd33, 18'h0, "R5");
        step(C_LSR, 0, 32'h8000_0000, 32'd2, 18'h0, "R5");
        step(C_ASR, 0, 32'h8000_0000, 32'd2, 18'h0, "R5");
        step(C_ASR, 0, 32'h4000_0000, 32'd30, 18'h0, "R5");
        // R6 register versus immediate operand
        step(C_ADD, 1, 32'd100, 32'd999, 18'h0_0005, "R6");
        step(C_ADD, 0, 32'd100, 32'd999, 18'h0_0005, "R6");
        // R7 extension modes on 0xA32B
        step(C_MOV, 1, 32'h0, 32'h0, {2'b00, 16'hA32B}, "R7");
        step(C_MOV, 1, 32'h0, 32'h0, {2'b01, 16'hA32B}, "R7");
        step(C_MOV, 1, 32'h0, 32'h0, {2'b10, 16'hA32B}, "R7");
        step(C_MOV, 1, 32'h0, 32'h0, {2'b11, 16'hA32B}, "R7");
        step(C_ADD, 1, 32'h12AB_0000, 32'h0, {2'b01, 16'hA92D}, "R7");
        // R8 compare outcomes, each seen on the following step
        step(C_CMP, 0, 32'd3, 32'd5, 18'h0, "R10");
        step(C_CMP, 0, 32'd5, 32'd3, 18'h0, "R10");
        step(C_CMP, 0, 32'd5, 32'd5, 18'h0, "R10");
        step(C_CMP, 0, 32'd1, 32'hFFFF_FFFF, 18'h0, "R10");
        step(C_CMP, 0, 32'hFFFF_FFFF, 32'd1, 18'h0, "R10");
        step(C_CMP, 1, 32'hFFFF_FFFD, 32'd0, {2'b00, 16'hFFFD}, "R10");
        // R9 non-compare ops leave eq=1 in place
        step(C_SUB, 0, 32'd9, 32'd9, 18'h0, "R9");
        step(C_ADD, 0, 32'd1, 32'd2, 18'h0, "R9");
        step(C_CMP, 0, 32'd8, 32'd2, 18'h0, "R10");
        step(C_MOV, 0, 32'd0, 32'd0, 18'h0, "R9");
        step(5'b01101, 0, 32'd4, 32'd4, 18'h0, "R10");
        step(5'b11111, 1, 32'd4, 32'd4, 18'h3_FFFF, "R10");
        step(C_NOT, 0, 32'd4, 32'd4, 18'h0, "R9");
        // R11 reset clears flags even with a compare presented
        step(C_CMP, 0, 32'd5, 32'd3, 18'h0, "R10");
        do_reset(2);
        step(C_MOV, 0, 32'd0, 32'd1, 18'h0, "R11");

        // Mixed pseudo-random operations
        for (int i = 0; i < 400; i++) begin
            r = next_rng();
            op = (r[7:4] == 4'd0) ? {2'b11, r[10:8]} : 5'(r[3:0] % 13);
            a = next_rng();
            b = next_rng();
            if (r[11]) a = {28'h0, a[3:0]};
            if (r[12]) b = {28'h0, b[3:0]};
            if (r[13]) b = a;
            step(op, r[14], a, b, r[31:14], r[14] ? "R6" : req_of(op));
        end
        step(C_MOV, 0, 32'd0, 32'd0, 18'h0, "R9");
        finish_run();
    end

endmodule